// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block holds received bytes for a 16550-style serial port. A deserializer hands it one byte per cycle (optionally marked as a break), and the CPU side pops bytes through a read strobe. A FIFO control write port sets the operating mode. With the FIFO enabled, bytes queue in a 16-entry buffer. A trigger flag rises once the fill reaches a selectable level. A character-timeout flag rises when data has sat unread for four character times. With the FIFO disabled, the block acts as a single holding register.

The character time is computed from the low line-control bits and a bit period given in clock cycles. The block also emits a one-cycle pulse that the transmit side uses to flush its own FIFO.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: In FIFO mode up to 16 bytes are held and returned in arrival order; `count_o` gives the fill, never above 16, and `rd_data_o` shows the oldest byte.
- R2: A byte arriving while 16 are held is discarded and sets `overrun_o`. In holding-register mode, a byte arriving while data-ready is set and no read occurs in the same cycle sets `overrun_o`. The flag stays set until a receive reset.
- R3: FCR bits 7:6 choose the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In FIFO mode `trig_hit_o` is high while the count is at or above that level. In holding-register mode it equals data-ready.
- R4: `fcr_o` keeps only bits 7, 6, 3 and 0 of the last effective write (mask 0xC9). A write whose value equals the current `fcr_o` changes nothing and produces no reset.
- R5: An effective write with bit 1 set empties the receive store and clears overrun, break, data-ready and timeout. An effective write with bit 2 set makes `tx_fifo_rst_o` high for exactly the cycle after the write.
- R6: A write that changes bit 0 (FIFO enable) acts as if bits 1 and 2 were also set.
- R7: In FIFO mode `data_ready_o` means the FIFO is non-empty. A read with the FIFO empty returns 0x00. A byte flagged as break is stored as 0x00 and sets `break_o`. A read that leaves the FIFO empty clears `break_o`, unless a break byte arrives in the same cycle.
- R8: In FIFO mode the timeout counter loads L = 4 × frame × `bit_period_i` cycles on every received byte and on every read that leaves data behind. Here frame = (LCR[1:0]+5) data bits + (LCR[2] ? 2 : 1) stop bits + LCR[3] parity bit. If no new load occurs, `timeout_o` rises L cycles after the last load when data is present. A read clears it.
- R9: With the FIFO disabled, a received byte is stored in one holding register and sets data-ready. A read clears data-ready. `rd_data_o` keeps showing the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | DW | Received byte |
| rx_break_i | input | 1 | Qualifies rx_valid_i as a break (stored as zero) |
| rd_i | input | 1 | CPU read of the receive buffer |
| rd_data_o | output | DW | Byte returned by a read this cycle |
| fcr_we_i | input | 1 | FIFO control write strobe |
| fcr_wdata_i | input | 8 | FIFO control write value |
| lcr_i | input | 4 | Line control: word length, stop bits, parity enable |
| bit_period_i | input | BP_W | Clock cycles per serial bit |
| fcr_o | output | 8 | Retained FIFO control bits |
| fifo_en_o | output | 1 | FIFO mode active |
| tx_fifo_rst_o | output | 1 | One-cycle transmit FIFO flush pulse |
| count_o | output | CNT_W | Receive FIFO fill |
| data_ready_o | output | 1 | Receive data available |
| trig_hit_o | output | 1 | Fill at or above trigger level |
| timeout_o | output | 1 | Character timeout pending |
| overrun_o | output | 1 | Byte lost |
| break_o | output | 1 | Break byte received |

## Verification
Some rules are checked by assertions on every cycle:
- the fill bound;
- a full FIFO staying full under a push;
- overrun stickiness;
- same-value FCR writes leaving the register untouched;
- an enable toggle emptying the store and pulsing the transmit flush;
- timeout never rising without data, and always dropping after a read;
- a holding-register receive setting data-ready.

Other behaviour can only be seen in the bench scenarios:
- the exact cycle on which the timeout fires for each line-control setting;
- the fill order;
- the four trigger levels;
- a break byte clearing when a read drains the FIFO.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  localparam logic [7:0] FCR_KEEP  = 8'hC9;
  localparam logic [7:0] FCR_FLUSH = 8'h06;

  function automatic int unsigned trig_level(trig_sel_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

  // data bits + stop bits + parity bit
  function automatic logic [3:0] frame_bits(logic [3:0] lcr);
    return 4'(lcr[1:0]) + 4'd5 + (lcr[2] ? 4'd2 : 4'd1) + 4'(lcr[3]);
  endfunction
endpackage

// File: rtl/rxf_fcr.sv
module rxf_fcr
  import rxf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] fcr_o,
  output logic       en_o,
  output trig_sel_e  sel_o,
  output logic       rx_clr_o,
  output logic       tx_rst_o
);
  logic [7:0] fcr_q, eff;
  logic       upd, tx_q;

  always_comb begin
    upd = we_i && (wdata_i != fcr_q);
    eff = wdata_i | ((wdata_i[0] ^ fcr_q[0]) ? FCR_FLUSH : 8'h00);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcr_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= upd && eff[2];
      if (upd) fcr_q <= eff & FCR_KEEP;
    end
  end

  assign rx_clr_o = upd && eff[1];
  assign tx_rst_o = tx_q;
  assign fcr_o    = fcr_q;
  assign en_o     = fcr_q[0];
  assign sel_o    = trig_sel_e'(fcr_q[7:6]);

  AST_SAME_FCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == fcr_q) |=> ($stable(fcr_q) && !tx_q)); // R4
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    dout_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o = empty_o ? '0 : mem_q[rd_q];
  assign cnt_o  = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o); // R2
endmodule

// File: rtl/rxf_tmo.sv
module rxf_tmo
  import rxf_pkg::*;
#(
  parameter int BP_W = 16,
  localparam int TMO_W = BP_W + 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            restart_i,
  input  logic            ack_i,
  input  logic            has_data_i,
  input  logic [3:0]      lcr_i,
  input  logic [BP_W-1:0] bit_period_i,
  output logic            pend_o
);
  logic [TMO_W-1:0] limit, cnt_q;
  logic             armed_q, pend_q, fire;

  always_comb begin
    limit = (TMO_W'(frame_bits(lcr_i)) * TMO_W'(bit_period_i)) << 2;
    fire  = armed_q && !restart_i && (cnt_q <= TMO_W'(1)) && has_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (restart_i) begin
        armed_q <= 1'b1;
        cnt_q   <= limit;
      end else if (armed_q) begin
        if (cnt_q <= TMO_W'(1)) armed_q <= 1'b0;
        else                    cnt_q   <= cnt_q - 1'b1;
      end
      if (ack_i)     pend_q <= 1'b0;
      else if (fire) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  AST_RD_CLEARS_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !pend_q); // R8
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int BP_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_break_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             fcr_we_i,
  input  logic [7:0]       fcr_wdata_i,
  input  logic [3:0]       lcr_i,
  input  logic [BP_W-1:0]  bit_period_i,
  output logic [7:0]       fcr_o,
  output logic             fifo_en_o,
  output logic             tx_fifo_rst_o,
  output logic [CNT_W-1:0] count_o,
  output logic             data_ready_o,
  output logic             trig_hit_o,
  output logic             timeout_o,
  output logic             overrun_o,
  output logic             break_o
);
  logic             en, rx_clr, live, f_push, f_pop, full, empty;
  logic [DW-1:0]    rx_byte, f_dout, hold_q;
  logic [CNT_W-1:0] cnt, lvl;
  logic             hold_full_q, ovr_q, brk_q, tmo_restart, tmo_clr;
  trig_sel_e        sel;

  rxf_fcr u_fcr (
    .clk_i, .rst_ni,
    .we_i     (fcr_we_i),
    .wdata_i  (fcr_wdata_i),
    .fcr_o    (fcr_o),
    .en_o     (en),
    .sel_o    (sel),
    .rx_clr_o (rx_clr),
    .tx_rst_o (tx_fifo_rst_o)
  );

  assign live    = !rx_clr;
  assign rx_byte = rx_break_i ? '0 : rx_data_i;
  assign f_push  = en && live && rx_valid_i;
  assign f_pop   = en && live && rd_i;

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (rx_clr),
    .push_i  (f_push),
    .pop_i   (f_pop),
    .din_i   (rx_byte),
    .dout_o  (f_dout),
    .cnt_o   (cnt),
    .full_o  (full),
    .empty_o (empty)
  );

  assign tmo_restart = en && live && (rx_valid_i || (rd_i && cnt > CNT_W'(1)));
  assign tmo_clr     = rx_clr || !en;

  rxf_tmo #(.BP_W(BP_W)) u_tmo (
    .clk_i, .rst_ni,
    .clr_i        (tmo_clr),
    .restart_i    (tmo_restart),
    .ack_i        (rd_i && en),
    .has_data_i   (!empty),
    .lcr_i        (lcr_i),
    .bit_period_i (bit_period_i),
    .pend_o       (timeout_o)
  );

  // holding register and line flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      ovr_q       <= 1'b0;
      brk_q       <= 1'b0;
    end else if (rx_clr) begin
      hold_full_q <= 1'b0;
      ovr_q       <= 1'b0;
      brk_q       <= 1'b0;
    end else begin
      if (!en) begin
        if (rx_valid_i) begin
          hold_q      <= rx_byte;
          hold_full_q <= 1'b1;
        end else if (rd_i) begin
          hold_full_q <= 1'b0;
        end
      end
      if (rx_valid_i && (en ? full : (hold_full_q && !rd_i))) ovr_q <= 1'b1;
      if (rx_valid_i && rx_break_i)
        brk_q <= 1'b1;
      else if (rd_i && (!en || (cnt <= CNT_W'(1) && !rx_valid_i)))
        brk_q <= 1'b0;
    end
  end

  assign lvl          = CNT_W'(trig_level(sel));
  assign fifo_en_o    = en;
  assign count_o      = cnt;
  assign rd_data_o    = en ? f_dout : hold_q;
  assign data_ready_o = en ? !empty : hold_full_q;
  assign trig_hit_o   = en ? (cnt >= lvl) : hold_full_q;
  assign overrun_o    = ovr_q;
  assign break_o      = brk_q;

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !rx_clr) |=> overrun_o); // R2
  AST_EN_TOGGLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && (fcr_wdata_i[0] != fcr_o[0])) |=> (count_o == '0 && tx_fifo_rst_o)); // R6
  AST_TMO_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> data_ready_o); // R8
  AST_HOLD_DR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && rx_valid_i && !rx_clr) |=> data_ready_o); // R9
endmodule

// File: tb/rx_fifo_ctrl_bench.sv
module rx_fifo_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int BP_W  = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_break = 0, rd = 0, fcr_we = 0;
  logic [7:0] rx_data = 0, fcr_wdata = 0;
  logic [3:0] lcr = 4'h3;
  logic [BP_W-1:0] bp = 16'd2;
  logic [7:0] rd_data, fcr;
  logic fifo_en, tx_rst, dr, trig, tmo, ovr, brk;
  logic [CNT_W-1:0] cnt;

  int n_vec = 0, n_bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_ctrl #(.DW(8), .DEPTH(DEPTH), .BP_W(BP_W)) u_rx_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .rd_i(rd), .rd_data_o(rd_data),
    .fcr_we_i(fcr_we), .fcr_wdata_i(fcr_wdata),
    .lcr_i(lcr), .bit_period_i(bp),
    .fcr_o(fcr), .fifo_en_o(fifo_en), .tx_fifo_rst_o(tx_rst), .count_o(cnt),
    .data_ready_o(dr), .trig_hit_o(trig), .timeout_o(tmo),
    .overrun_o(ovr), .break_o(brk)
  );

  // behavioural reference
  logic [7:0] q[$];
  logic [7:0] m_fcr = 0, m_hold = 0;
  bit m_hold_full = 0, m_ovr = 0, m_brk = 0, m_pend = 0, m_armed = 0, m_tx = 0;
  int m_tcnt = 0;

  function automatic int tmo_limit();
    return 4 * ((lcr[1:0] + 5) + (lcr[2] ? 2 : 1) + lcr[3]) * bp;
  endfunction

  function automatic int level_of(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_fcr = 0; m_hold = 0; m_hold_full = 0; m_ovr = 0; m_brk = 0;
      m_pend = 0; m_armed = 0; m_tx = 0; m_tcnt = 0;
    end else begin
      logic [7:0] v;
      bit en, rxc, restart, fire;
      int sz0;
      en = m_fcr[0]; rxc = 0; m_tx = 0;
      if (fcr_we && fcr_wdata != m_fcr) begin
        v = fcr_wdata;
        if (v[0] != m_fcr[0]) v = v | 8'h06;
        m_tx = v[2]; rxc = v[1];
        m_fcr = v & 8'hC9;
      end
      if (rxc) begin
        q.delete(); m_hold_full = 0; m_ovr = 0; m_brk = 0; m_pend = 0; m_armed = 0; m_tcnt = 0;
      end else if (en) begin
        sz0 = q.size();
        restart = rx_valid || (rd && sz0 > 1);
        fire = m_armed && !restart && m_tcnt <= 1 && sz0 != 0;
        if (restart) begin m_armed = 1; m_tcnt = tmo_limit(); end
        else if (m_armed) begin if (m_tcnt <= 1) m_armed = 0; else m_tcnt--; end
        if (rd) m_pend = 0; else if (fire) m_pend = 1;
        if (rx_valid && sz0 == DEPTH) m_ovr = 1;
        if (rx_valid && rx_break) m_brk = 1;
        else if (rd && sz0 <= 1 && !rx_valid) m_brk = 0;
        if (rd && sz0 > 0) void'(q.pop_front());
        if (rx_valid && sz0 < DEPTH) q.push_back(rx_break ? 8'h00 : rx_data);
      end else begin
        m_armed = 0; m_pend = 0; m_tcnt = 0;
        if (rx_valid && m_hold_full && !rd) m_ovr = 1;
        if (rx_valid && rx_break) m_brk = 1; else if (rd) m_brk = 0;
        if (rx_valid) begin m_hold = rx_break ? 8'h00 : rx_data; m_hold_full = 1; end
        else if (rd) m_hold_full = 0;
      end
    end
  end

  task automatic chk(string tag, string nm, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit en;
    en = m_fcr[0];
    chk("R1", "count", 16'(cnt), 16'(q.size()));
    chk("R1 R7 R9", "rd_data", 16'(rd_data),
        16'(en ? (q.size() != 0 ? q[0] : 8'h00) : m_hold));
    chk("R7 R9", "data_ready", 16'(dr), 16'(en ? (q.size() != 0) : m_hold_full));
    chk("R3", "trig_hit", 16'(trig), 16'(en ? (q.size() >= level_of(m_fcr[7:6])) : m_hold_full));
    chk("R4", "fcr", 16'(fcr), 16'(m_fcr));
    chk("R6", "fifo_en", 16'(fifo_en), 16'(en));
    chk("R5", "tx_rst", 16'(tx_rst), 16'(m_tx));
    chk("R8", "timeout", 16'(tmo), 16'(m_pend));
    chk("R2", "overrun", 16'(ovr), 16'(m_ovr));
    chk("R7", "break", 16'(brk), 16'(m_brk));
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic step(bit v, logic [7:0] d, bit b, bit r, bit w, logic [7:0] wd);
    @(posedge clk); #1;
    rx_valid = v; rx_data = d; rx_break = b; rd = r; fcr_we = w; fcr_wdata = wd;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask
  task automatic push(logic [7:0] d); step(1, d, 0, 0, 0, 0); endtask
  task automatic pull(); step(0, 0, 0, 1, 0, 0); endtask
  task automatic wfcr(logic [7:0] v); step(0, 0, 0, 0, 1, v); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2);
    // R9: holding register mode
    push(8'hA5); idle(1); pull(); idle(1);
    push(8'h11); push(8'h22); idle(1);           // R2 overrun by overwrite
    step(1, 8'h77, 1, 0, 0, 0); pull(); idle(1); // R7 break in holding mode
    step(1, 8'h33, 0, 1, 0, 0); idle(1);         // read and receive together
    // R6: enable FIFO, level 4
    wfcr(8'h41); idle(1);
    @(negedge clk); chk("R6", "count after enable", 16'(cnt), 16'd0);
    for (int i = 0; i < 3; i++) push(8'(8'h10 + i));
    idle(1);
    push(8'h13); idle(1);                        // R3 level 4 reached
    pull(); pull(); idle(2);
    // R8: wait for timeout
    idle(80);
    @(negedge clk); chk("R8", "timeout fired", 16'(tmo), 16'd1);
    pull(); idle(3); pull(); idle(3); pull(); idle(3); // R7 read from empty
    // R1/R2: fill past depth
    for (int i = 0; i < 18; i++) push(8'(8'h40 + i));
    idle(1);
    wfcr(8'h41); idle(1);                         // R4 same value ignored
    for (int i = 0; i < 5; i++) pull();
    wfcr(8'h43); idle(2);                         // R5 receive reset
    wfcr(8'h45); idle(2);                         // R5 transmit reset pulse
    // R3 remaining levels
    wfcr(8'h81);
    for (int i = 0; i < 9; i++) push(8'(i));
    wfcr(8'hC1);
    for (int i = 0; i < 6; i++) push(8'(8'h80 + i));
    wfcr(8'h00); idle(1);                         // R6 back to holding mode, flush
    @(negedge clk); chk("R6", "count after disable", 16'(cnt), 16'd0);
    // R8: other frame length, break bytes in FIFO
    wfcr(8'h09); lcr = 4'hF;
    step(1, 8'h55, 1, 0, 0, 0); push(8'h66); idle(30); pull(); idle(95);
    pull(); idle(2);                              // R7 drained: break clears
    step(1, 8'h00, 1, 0, 0, 0); idle(1); pull(); idle(100);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule